// File: doc/BRIEF.md
# Field Memory Serial Write Port

This block is the write side of a sequential-access field memory. On its own write clock it accepts 12-bit words and turns them into write requests (address, data, strobe) for a plain synchronous RAM. A write address pointer sets where each word goes. A segment restart input sends the pointer back to zero. A write enable gates both the capture of words and the advance of the pointer. An input enable masks the store of a word into the array but still lets the pointer move.

Each captured word first waits in a one-word staging register. It is sent to the array on the next event that moves data: either the next enabled capture or a segment restart. This one-clock lag lets write ports be chained behind read ports with no extra delay parts. It also means the last word of a segment reaches the array only when a restart follows it. The block raises a sticky flag when a restart comes back too soon.

Top module: `fieldmem_wr_port`

## Requirements
- R1: When the system reset is released, `mem_we` is 0 and `proto_err` is 0.
- R2: A clock edge that samples `seg_rst` high sets the pointer to zero. The first word captured after that edge is requested at address 0.
- R3: On an edge that samples `seg_rst` high, the levels of `wr_en` and `in_en` have no effect. No word is captured from `din` on that edge.
- R4: A clock edge that samples `wr_en` high and `seg_rst` low captures `din` at the current pointer. The pointer then advances by one, so consecutive words are requested at consecutive addresses.
- R5: An edge that samples `wr_en` low and `seg_rst` low captures nothing, leaves the pointer unchanged and raises no request. `mem_we` is 0 after it, and `mem_addr` and `mem_data` keep their values. This holds for any length of idle time.
- R6: A word captured with `in_en` low never produces a request. The pointer still advances past its address.
- R7: A staged word is requested one event late. `mem_we` goes to 1, carrying that word's address and data, after the next edge that is an enabled capture or a restart. `mem_we` is 1 only after such an edge.
- R8: When a restart edge follows the last capture, the staged word is requested after that restart edge, at its original address.
- R9: The pointer wraps from DEPTH-1 to 0.
- R10: `proto_err` is set when a restart edge comes after an earlier restart with fewer than two low-sampled edges of `seg_rst` in between. Once set, it stays set until the system reset. Holding `seg_rst` high over several edges does not count as a new restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset |
| seg_rst | input | 1 | Segment restart, sampled on the rising edge |
| wr_en | input | 1 | Capture and pointer-advance enable |
| in_en | input | 1 | Array store mask (0 = store suppressed) |
| din | input | W | Input word |
| mem_addr | output | AW | Write request address |
| mem_data | output | W | Write request data |
| mem_we | output | 1 | Write request strobe, one cycle per request |
| proto_err | output | 1 | Sticky restart-spacing violation flag |

## Verification
A word captured at edge k shows on the request port only after the next capture or restart edge m > k, and it shows there for exactly the cycle after m. The protocol flag changes right after the offending restart edge. The bench drives each input on the falling edge, lets one rising edge occur, and reads the outputs on the next falling edge, so each check sees the result of exactly one edge. Expected addresses come from a pointer count kept in the bench. That count starts at zero on each restart and moves only on enabled captures, wrapping at DEPTH.

// File: rtl/fmw_pkg.sv
package fmw_pkg;
  // Event seen at one write clock edge
  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_CAPTURE = 2'd1,
    EV_FLUSH   = 2'd2
  } fmw_ev_e;

  function automatic fmw_ev_e fmw_decode(input logic rst_lvl, input logic en_lvl);
    if (rst_lvl)     return EV_FLUSH;
    else if (en_lvl) return EV_CAPTURE;
    else             return EV_NONE;
  endfunction
endpackage

// File: rtl/fmw_ptr.sv
module fmw_ptr #(
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fmw_pkg::fmw_ev_e ev,
  output logic [AW-1:0] ptr
);
  import fmw_pkg::*;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_n;
  logic          ptr_ce;

  always_comb begin
    ptr_ce = (ev != EV_NONE);
    ptr_n  = ptr;
    if (ev == EV_FLUSH)        ptr_n = '0;
    else if (ev == EV_CAPTURE) ptr_n = (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_ce) ptr <= ptr_n;
  end
endmodule

// File: rtl/fmw_stage.sv
module fmw_stage #(
  parameter int W  = 12,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fmw_pkg::fmw_ev_e ev,
  input  logic [AW-1:0] ptr,
  input  logic [W-1:0]  din,
  input  logic          in_en,
  output logic [AW-1:0] req_addr,
  output logic [W-1:0]  req_data,
  output logic          req_we
);
  import fmw_pkg::*;

  logic [AW-1:0] st_addr;
  logic [W-1:0]  st_data;
  logic          st_vld, st_vld_n;
  logic          st_ce, req_ce, req_we_n, push;

  always_comb begin
    push     = (ev != EV_NONE);
    req_ce   = push && st_vld;
    req_we_n = push && st_vld;
    st_ce    = (ev == EV_CAPTURE);
    st_vld_n = st_vld;
    if (ev == EV_CAPTURE)    st_vld_n = in_en;
    else if (ev == EV_FLUSH) st_vld_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_addr <= '0;
      st_data <= '0;
    end else if (st_ce) begin
      st_addr <= ptr;
      st_data <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_vld <= 1'b0;
    else        st_vld <= st_vld_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr <= '0;
      req_data <= '0;
    end else if (req_ce) begin
      req_addr <= st_addr;
      req_data <= st_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_we <= 1'b0;
    else        req_we <= req_we_n;
  end
endmodule

// File: rtl/fmw_guard.sv
module fmw_guard #(
  parameter int MIN_LOW = 2,
  localparam int CW = $clog2(MIN_LOW + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seg_rst,
  output logic err
);
  logic [CW-1:0] lo_cnt, lo_cnt_n;
  logic          prev_hi, seen, seen_n, err_n, rise;

  always_comb begin
    rise     = seg_rst && !prev_hi;
    lo_cnt_n = lo_cnt;
    if (seg_rst)                    lo_cnt_n = '0;
    else if (lo_cnt != CW'(MIN_LOW)) lo_cnt_n = lo_cnt + 1'b1;
    seen_n = seen || seg_rst;
    err_n  = err || (rise && seen && (lo_cnt < CW'(MIN_LOW)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt  <= '0;
      prev_hi <= 1'b0;
      seen    <= 1'b0;
      err     <= 1'b0;
    end else begin
      lo_cnt  <= lo_cnt_n;
      prev_hi <= seg_rst;
      seen    <= seen_n;
      err     <= err_n;
    end
  end
endmodule

// File: rtl/fieldmem_wr_port.sv
module fieldmem_wr_port #(
  parameter int W     = 12,
  parameter int DEPTH = 256,
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seg_rst,
  input  logic          wr_en,
  input  logic          in_en,
  input  logic [W-1:0]  din,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_data,
  output logic          mem_we,
  output logic          proto_err
);
  import fmw_pkg::*;

  // Asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  fmw_ev_e       ev;
  logic [AW-1:0] ptr;

  always_comb ev = fmw_decode(seg_rst, wr_en);

  fmw_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_core_n), .ev(ev), .ptr(ptr)
  );

  fmw_stage #(.W(W), .AW(AW)) u_stage (
    .clk(clk), .rst_n(rst_core_n), .ev(ev), .ptr(ptr), .din(din),
    .in_en(in_en), .req_addr(mem_addr), .req_data(mem_data), .req_we(mem_we)
  );

  fmw_guard #(.MIN_LOW(2)) u_guard (
    .clk(clk), .rst_n(rst_core_n), .seg_rst(seg_rst), .err(proto_err)
  );
endmodule

// File: rtl/fieldmem_wr_port_chk.sv
module fieldmem_wr_port_chk #(
  parameter int W  = 12,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          seg_rst,
  input logic          wr_en,
  input logic          in_en,
  input logic [AW-1:0] mem_addr,
  input logic [W-1:0]  mem_data,
  input logic          mem_we,
  input logic          proto_err
);
  // R5: idle edge raises no request
  p_idle_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!seg_rst && !wr_en) |=> !mem_we);

  // R5: idle edge keeps request address and data
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!seg_rst && !wr_en) |=> ($stable(mem_addr) && $stable(mem_data)));

  // R7: strobe only after a capture or restart edge
  p_we_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(wr_en) || $past(seg_rst)));

  // R2: first stored word after a restart lands at address 0
  p_restart_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seg_rst) && !seg_rst && wr_en && in_en) ##1 (!seg_rst && wr_en)
      |=> (mem_we && mem_addr == '0));

  // R10: flag is sticky
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R10: restart after a single low edge sets the flag
  p_short_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_rst && !$past(seg_rst) && $past(seg_rst, 2)) |=> proto_err);
endmodule

bind fieldmem_wr_port fieldmem_wr_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .seg_rst(seg_rst), .wr_en(wr_en),
  .in_en(in_en), .mem_addr(mem_addr), .mem_data(mem_data),
  .mem_we(mem_we), .proto_err(proto_err)
);

// File: tb/sim_fieldmem_wr_port.sv
`timescale 1ns/1ps
module sim_fieldmem_wr_port;
  localparam int W     = 12;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          seg_rst, wr_en, in_en;
  logic [W-1:0]  din;
  logic [AW-1:0] mem_addr;
  logic [W-1:0]  mem_data;
  logic          mem_we, proto_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fieldmem_wr_port #(.W(W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .seg_rst(seg_rst), .wr_en(wr_en), .in_en(in_en),
    .din(din), .mem_addr(mem_addr), .mem_data(mem_data), .mem_we(mem_we),
    .proto_err(proto_err)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // One edge: drive after a falling edge, sample at the next falling edge
  task automatic step(input logic r, input logic e, input logic ie, input logic [W-1:0] d);
    seg_rst = r; wr_en = e; in_en = ie; din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic sys_reset();
    rst_n = 1'b0; seg_rst = 1'b0; wr_en = 1'b0; in_en = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    sys_reset();
    chk("R1", "mem_we", int'(mem_we), 0);
    chk("R1", "proto_err", int'(proto_err), 0);
  endtask

  task automatic t_sequence();
    step(1'b1, 1'b0, 1'b0, '0);
    step(1'b0, 1'b1, 1'b1, 12'hA00);
    chk("R7", "we after first capture", int'(mem_we), 0);
    step(1'b0, 1'b1, 1'b1, 12'hA01);
    chk("R2", "addr of first word", int'(mem_addr), 0);
    chk("R7", "data of first word", int'(mem_data), 'hA00);
    chk("R7", "we", int'(mem_we), 1);
    step(1'b0, 1'b1, 1'b1, 12'hA02);
    chk("R4", "addr of second word", int'(mem_addr), 1);
    chk("R4", "data of second word", int'(mem_data), 'hA01);
    step(1'b0, 1'b0, 1'b1, 12'hFFF);
    chk("R5", "we after idle edge", int'(mem_we), 0);
    chk("R5", "addr held", int'(mem_addr), 1);
    idle(40);
    chk("R5", "we after long idle", int'(mem_we), 0);
    // restart with enables high and a junk word on din
    step(1'b1, 1'b1, 1'b1, 12'hBAD);
    chk("R8", "flush we", int'(mem_we), 1);
    chk("R8", "flush addr", int'(mem_addr), 2);
    chk("R8", "flush data", int'(mem_data), 'hA02);
    step(1'b0, 1'b1, 1'b1, 12'hC00);
    chk("R3", "no word from restart edge", int'(mem_we), 0);
    step(1'b0, 1'b1, 1'b1, 12'hC01);
    chk("R3", "addr after restart", int'(mem_addr), 0);
    chk("R3", "data after restart", int'(mem_data), 'hC00);
    step(1'b0, 1'b0, 1'b0, '0);
    chk("R7", "single-cycle strobe", int'(mem_we), 0);
    idle(2);
    chk("R10", "no flag on legal spacing", int'(proto_err), 0);
  endtask

  task automatic t_mask();
    step(1'b1, 1'b0, 1'b0, '0);
    step(1'b0, 1'b1, 1'b1, 12'hD00);
    step(1'b0, 1'b1, 1'b0, 12'hD01);
    chk("R6", "word before masked one addr", int'(mem_addr), 0);
    chk("R6", "word before masked one data", int'(mem_data), 'hD00);
    step(1'b0, 1'b1, 1'b1, 12'hD02);
    chk("R6", "masked word not requested", int'(mem_we), 0);
    step(1'b1, 1'b0, 1'b0, '0);
    chk("R6", "pointer advanced past masked", int'(mem_addr), 2);
    chk("R6", "data after mask", int'(mem_data), 'hD02);
    chk("R8", "flush we", int'(mem_we), 1);
    idle(3);
  endtask

  task automatic t_wrap();
    step(1'b1, 1'b0, 1'b0, '0);
    for (int i = 0; i <= DEPTH; i++) begin
      step(1'b0, 1'b1, 1'b1, W'(12'h100 + i));
      if (i >= 1) begin
        chk("R4", "we in burst", int'(mem_we), 1);
        chk("R9", "burst addr", int'(mem_addr), (i - 1) % DEPTH);
        chk("R4", "burst data", int'(mem_data), 'h100 + i - 1);
      end
    end
    step(1'b1, 1'b0, 1'b0, '0);
    chk("R9", "wrapped addr", int'(mem_addr), 0);
    chk("R9", "wrapped data", int'(mem_data), 'h100 + DEPTH);
    idle(3);
  endtask

  task automatic t_proto();
    step(1'b1, 1'b0, 1'b0, '0);
    step(1'b1, 1'b0, 1'b0, '0);
    chk("R10", "held restart is not a new one", int'(proto_err), 0);
    idle(2);
    step(1'b1, 1'b0, 1'b0, '0);
    chk("R10", "two low edges legal", int'(proto_err), 0);
    idle(1);
    step(1'b1, 1'b0, 1'b0, '0);
    chk("R10", "one low edge flagged", int'(proto_err), 1);
    idle(5);
    chk("R10", "flag sticky", int'(proto_err), 1);
    sys_reset();
    chk("R10", "flag cleared by system reset", int'(proto_err), 0);
  endtask

  initial begin
    t_reset_state();
    t_sequence();
    t_mask();
    t_wrap();
    t_proto();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule